// File: doc/BRIEF.md
# Switching clock synchronization controller

This block derives the fixed-rate switching tick of a converter's digital control section from a fast system clock. With no activity on the shared synchronization line it runs as master. It raises `swTick` once per switching period and drives a pulse onto the line half a period after each tick. The period comes from a programmable input, limited to the range between the default rate and four times that rate.

The shared line is modelled as a sense input and a drive output with a separate enable. The sense input passes through a two-stage synchronizer and a minimum-width filter. Each accepted pulse counts once, at its rising edge. While the block drives the line itself, the sense input is masked.

A foreign device that runs faster than this one shows up as two accepted pulses within one of this block's own periods. When that happens the block becomes slave. From then on its tick follows each accepted pulse after a fixed latency, and it stops enabling the line driver. If the foreign pulses stop, the block returns to master after one period plus a margin.

Top module: `sw_sync_ctrl`

## Requirements
- R1: During reset and right after it, `swTick`, `syncDrive`, `syncDriveEn` and `isSlave` are low. The first tick comes exactly P system-clock cycles after reset is released, where P is the effective period. A reset taken while the block is slave returns it to master.
- R2: With `periodCfg` equal to 0, ticks are spaced exactly `DEF_PERIOD` cycles apart.
- R3: A non-zero `periodCfg` sets the tick spacing to its value, limited to the range [`DEF_PERIOD`/4, `DEF_PERIOD`]. A value below the range gives `DEF_PERIOD`/4, and a value above it gives `DEF_PERIOD`.
- R4: As master, `syncDrive` rises exactly floor(P/2) cycles after each tick and stays high for `OUT_PW` cycles, with `syncDriveEn` equal to `syncDrive`.
- R5: The block's own driven pulse, seen back on `syncIn`, is never taken as a foreign pulse.
- R6: Foreign pulses that arrive no more than once per own period leave the block master, with ticks still spaced P apart.
- R7: A second accepted foreign pulse within one own period makes `isSlave` high. As slave, every accepted pulse produces a tick exactly `MIN_IN_PW`+2 cycles after `syncIn` rises, so ticks follow the foreign rate.
- R8: As slave, `syncDriveEn` stays low. `syncDrive` still pulses floor(P/2) cycles after each tick.
- R9: A `syncIn` pulse that is high for fewer than `MIN_IN_PW` synchronized cycles is ignored: it neither produces a tick nor changes the role.
- R10: A `syncIn` level held high counts as a single pulse.
- R11: As slave, if no pulse is accepted for P+`MARGIN` cycles after the last tick, a tick is issued on that cycle and `isSlave` falls with it. Master ticks then resume every P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodCfg | input | CNT_W | Requested period in system cycles; 0 selects the default |
| syncIn | input | 1 | Sensed level of the shared sync line |
| swTick | output | 1 | One-cycle switching tick |
| syncDrive | output | 1 | Sync pulse level to place on the line |
| syncDriveEn | output | 1 | Enable for the line driver |
| isSlave | output | 1 | High while locked to a foreign master |

## Verification
Several properties are checked on every cycle by the assertions: a filtered pulse is accepted once and only after the synchronized line has been high, two ticks never fall on adjacent cycles, and the role changes only on an accepted pulse (entry) or on an expiry without one (exit). The exact tick spacing for every period setting, the half-period drive offset and width, and the fixed tick latency behind a foreign pulse can only be shown by the bench scenarios. The same holds for rejection of narrow pulses, the single count of a held line, and the timeout back to master.

// File: rtl/sw_sync_pkg.sv
package sw_sync_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic tickNow;   // restart the phase counter and issue a tick
    logic slave;     // current role, selects limit and drive enable
  } ctl_strobe_t;

  // Events from datapath to control
  typedef struct packed {
    logic extAccept; // a filtered foreign pulse was accepted this cycle
    logic expire;    // phase counter reached its current limit
  } dp_flags_t;

endpackage

// File: rtl/sw_sync_dp.sv
module sw_sync_dp
  import sw_sync_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DEF_PERIOD  = 400,
  parameter int OUT_PW      = 11,
  parameter int MIN_IN_PW   = 7,
  parameter int MARGIN      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncIn,
  input  ctl_strobe_t      strobe,
  output dp_flags_t        flags,
  output logic             swTick,
  output logic             syncDrive,
  output logic             syncDriveEn
);

  localparam int MIN_PERIOD = DEF_PERIOD / 4;
  localparam int PW_W       = $clog2(OUT_PW + 1);
  localparam int HI_W       = $clog2(MIN_IN_PW + 1);

  logic [CNT_W-1:0]       effPeriod;
  logic [CNT_W-1:0]       halfPt;
  logic [CNT_W-1:0]       limit;
  logic [CNT_W-1:0]       phaseCnt;
  logic [PW_W-1:0]        drvCnt;
  logic [HI_W-1:0]        hiCnt;
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   senseRaw;
  logic                   sensed;

  // Effective period, clamped to the supported range
  always_comb begin
    if (periodCfg == '0 || periodCfg > CNT_W'(DEF_PERIOD))
      effPeriod = CNT_W'(DEF_PERIOD);
    else if (periodCfg < CNT_W'(MIN_PERIOD))
      effPeriod = CNT_W'(MIN_PERIOD);
    else
      effPeriod = periodCfg;
  end

  assign halfPt = effPeriod >> 1;
  assign limit  = strobe.slave ? (effPeriod + CNT_W'(MARGIN) - CNT_W'(1))
                               : (effPeriod - CNT_W'(1));

  // Sense path: mask own drive, then synchronize
  assign senseRaw = syncIn & ~syncDriveEn;
  assign sensed   = syncPipe[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= senseRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], senseRaw};
      end
    end
  endgenerate

  // Width filter: saturating run-length count of the synchronized level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hiCnt <= '0;
    else if (!sensed)
      hiCnt <= '0;
    else if (hiCnt != HI_W'(MIN_IN_PW))
      hiCnt <= hiCnt + HI_W'(1);
  end

  assign flags.extAccept = sensed && (hiCnt == HI_W'(MIN_IN_PW - 1));
  assign flags.expire    = (phaseCnt >= limit);

  // Phase counter and tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      swTick   <= 1'b0;
    end else if (strobe.tickNow) begin
      phaseCnt <= '0;
      swTick   <= 1'b1;
    end else begin
      phaseCnt <= phaseCnt + CNT_W'(1);
      swTick   <= 1'b0;
    end
  end

  // Half-period sync pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      drvCnt <= '0;
    else if (!strobe.tickNow && phaseCnt == halfPt - CNT_W'(1))
      drvCnt <= PW_W'(OUT_PW);
    else if (drvCnt != '0)
      drvCnt <= drvCnt - PW_W'(1);
  end

  assign syncDrive   = (drvCnt != '0);
  assign syncDriveEn = syncDrive & ~strobe.slave;

  // R10: a held level yields one acceptance only
  a_r10_single_accept: assert property (@(posedge clk) disable iff (!rstN)
    flags.extAccept |=> !flags.extAccept);

  // R9: acceptance only after the synchronized line was already high
  a_r9_width_before_accept: assert property (@(posedge clk) disable iff (!rstN)
    flags.extAccept |-> $past(sensed));

  // R3: the minimum period keeps ticks off adjacent cycles
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    swTick |=> !swTick);

endmodule

// File: rtl/sw_sync_ctl.sv
module sw_sync_ctl
  import sw_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_flags_t   flags,
  output ctl_strobe_t strobe,
  output logic        isSlave
);

  logic slaveQ;
  logic seenQ;
  logic takeExt;

  // A foreign pulse becomes the tick when already slave, or when it is
  // the second accepted pulse inside one own period.
  assign takeExt        = flags.extAccept && (slaveQ || seenQ);
  assign strobe.tickNow = flags.expire || takeExt;
  assign strobe.slave   = slaveQ;
  assign isSlave        = slaveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      slaveQ <= 1'b0;
    else if (takeExt)
      slaveQ <= 1'b1;
    else if (flags.expire)
      slaveQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      seenQ <= 1'b0;
    else if (strobe.tickNow)
      seenQ <= 1'b0;
    else if (flags.extAccept && !slaveQ)
      seenQ <= 1'b1;
  end

  // R7: slave role is entered only on an accepted pulse
  a_r7_slave_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slaveQ) |-> $past(flags.extAccept));

  // R11: slave role is left only on expiry without a pulse
  a_r11_slave_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slaveQ) |-> ($past(flags.expire) && !$past(flags.extAccept)));

  // R7: a master tick not caused by expiry means the role switched
  a_r7_ext_tick_role: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveQ && strobe.tickNow && !flags.expire) |=> slaveQ);

endmodule

// File: rtl/sw_sync_ctrl.sv
module sw_sync_ctrl
  import sw_sync_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DEF_PERIOD  = 400,
  parameter int OUT_PW      = 11,
  parameter int MIN_IN_PW   = 7,
  parameter int MARGIN      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncIn,
  output logic             swTick,
  output logic             syncDrive,
  output logic             syncDriveEn,
  output logic             isSlave
);

  ctl_strobe_t strobe;
  dp_flags_t   flags;

  sw_sync_dp #(
    .CNT_W      (CNT_W),
    .DEF_PERIOD (DEF_PERIOD),
    .OUT_PW     (OUT_PW),
    .MIN_IN_PW  (MIN_IN_PW),
    .MARGIN     (MARGIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .periodCfg  (periodCfg),
    .syncIn     (syncIn),
    .strobe     (strobe),
    .flags      (flags),
    .swTick     (swTick),
    .syncDrive  (syncDrive),
    .syncDriveEn(syncDriveEn)
  );

  sw_sync_ctl ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .flags  (flags),
    .strobe (strobe),
    .isSlave(isSlave)
  );

  // R8: as slave the line driver is never enabled
  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    isSlave |-> !syncDriveEn);

endmodule

// File: tb/sw_sync_ctrl_tb_top.sv
module sw_sync_ctrl_tb_top;

  localparam int CNT_W  = 8;
  localparam int DEF    = 40;
  localparam int OPW    = 5;
  localparam int MINW   = 4;
  localparam int MARGIN = 8;
  localparam int MINP   = DEF / 4;
  localparam int LAT    = MINW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] periodCfg = '0;
  logic extDrv = 1'b0;
  logic extHold = 1'b0;
  logic syncIn;
  logic swTick, syncDrive, syncDriveEn, isSlave;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int extPeriod = 0;
  int extWidth = 6;
  int extPh = 0;
  int extRise = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Shared line: foreign drive, held level, and own enabled drive
  assign syncIn = extDrv | extHold | (syncDriveEn & syncDrive);

  sw_sync_ctrl #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF), .OUT_PW(OPW),
    .MIN_IN_PW(MINW), .MARGIN(MARGIN), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .syncIn(syncIn),
    .swTick(swTick), .syncDrive(syncDrive), .syncDriveEn(syncDriveEn),
    .isSlave(isSlave)
  );

  // Foreign pulse generator, updated on the falling edge
  always @(negedge clk) begin
    logic nextDrv;
    if (extPeriod > 0) begin
      if (extPh >= extPeriod - 1) extPh = 0;
      else extPh = extPh + 1;
      nextDrv = (extPh < extWidth);
    end else begin
      extPh = 0;
      nextDrv = 1'b0;
    end
    if (nextDrv && !extDrv) extRise <= cyc;
    extDrv <= nextDrv;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTick(output int t);
    do @(negedge clk); while (!swTick);
    t = cyc;
  endtask

  function automatic int expPeriod(input int cfg);
    if (cfg == 0 || cfg > DEF) return DEF;
    if (cfg < MINP) return MINP;
    return cfg;
  endfunction

  initial begin : watchdog
    wait (cyc >= 100000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int a, b, t, t2, t3, r, t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(swTick == 0, "R1 tick in reset", swTick, 0);
    chk(syncDrive == 0, "R1 drive in reset", syncDrive, 0);
    chk(syncDriveEn == 0, "R1 enable in reset", syncDriveEn, 0);
    chk(isSlave == 0, "R1 role in reset", isSlave, 0);
    rstN = 1'b1;
    t0 = cyc;
    waitTick(t);
    chk(t - t0 == DEF, "R1 first tick", t - t0, DEF);

    // R2 default period
    waitTick(a);
    waitTick(b);
    chk(b - a == DEF, "R2 default spacing", b - a, DEF);

    // R3 / R4 sweep of every period setting
    for (int cfg = 0; cfg < 64; cfg++) begin
      int exp, rise, width, enBad;
      waitTick(a);
      periodCfg = CNT_W'(cfg);
      exp = expPeriod(cfg);
      rise = -1; width = 0; enBad = 0;
      do begin
        @(negedge clk);
        if (!swTick) begin
          if (syncDrive) begin
            if (rise < 0) rise = cyc - a;
            width++;
          end
          if (syncDriveEn != syncDrive) enBad++;
        end
      end while (!swTick);
      b = cyc;
      chk(b - a == exp, (cfg == 0) ? "R2 spacing cfg 0" : "R3 spacing", b - a, exp);
      chk(rise == exp / 2, "R4 drive offset", rise, exp / 2);
      chk(width == OPW, "R4 drive width", width, OPW);
      chk(enBad == 0, "R4 enable follows drive", enBad, 0);
    end
    periodCfg = '0;
    waitTick(a);

    // R5 / R6 slower foreign pulses with own loopback
    extWidth = 6;
    extPeriod = 60;
    waitTick(a);
    for (int i = 0; i < 15; i++) begin
      waitTick(b);
      chk(b - a == DEF, "R6 master spacing kept", b - a, DEF);
      chk(isSlave == 0, "R5 own pulse ignored, stays master", isSlave, 0);
      a = b;
    end

    // R9 narrow pulses are ignored
    extPeriod = 10;
    extWidth = MINW - 1;
    waitTick(a);
    for (int i = 0; i < 10; i++) begin
      waitTick(b);
      chk(b - a == DEF, "R9 narrow pulses no tick", b - a, DEF);
      chk(isSlave == 0, "R9 narrow pulses no role change", isSlave, 0);
      a = b;
    end
    extWidth = MINW;
    for (int i = 0; i < 300 && !isSlave; i++) @(negedge clk);
    chk(isSlave == 1, "R9 full-width pulses accepted", isSlave, 1);

    // R7 / R8 locked to a faster foreign rate
    extPeriod = 30;
    extWidth = 6;
    waitTick(a);
    waitTick(a);
    for (int i = 0; i < 6; i++) begin
      int drv, en;
      drv = 0; en = 0;
      do begin
        @(negedge clk);
        if (!swTick) begin
          if (syncDrive) drv++;
          if (syncDriveEn) en++;
        end
      end while (!swTick);
      b = cyc;
      chk(b - a == 30, "R7 follows foreign rate", b - a, 30);
      chk(b - extRise == LAT, "R7 tick latency", b - extRise, LAT);
      chk(isSlave == 1, "R7 slave flag", isSlave, 1);
      chk(en == 0, "R8 enable low as slave", en, 0);
      chk(drv == OPW, "R8 drive still pulses", drv, OPW);
      a = b;
    end

    // R10 / R11 held line, then timeout back to master
    waitTick(a);
    extPeriod = 0;
    @(negedge clk);
    @(negedge clk);
    extHold = 1'b1;
    r = cyc;
    waitTick(t);
    chk(t - r == LAT, "R10 held line tick latency", t - r, LAT);
    waitTick(t2);
    chk(t2 - t == DEF + MARGIN, "R10 R11 held line counts once, timeout", t2 - t, DEF + MARGIN);
    chk(isSlave == 0, "R11 back to master", isSlave, 0);
    extHold = 1'b0;
    waitTick(t3);
    chk(t3 - t2 == DEF, "R11 master spacing resumes", t3 - t2, DEF);
    chk(isSlave == 0, "R11 stays master", isSlave, 0);

    // R1 reset while slave
    extPeriod = 30;
    for (int i = 0; i < 300 && !isSlave; i++) @(negedge clk);
    chk(isSlave == 1, "R1 slave before reset", isSlave, 1);
    rstN = 1'b0;
    extPeriod = 0;
    @(negedge clk);
    chk(isSlave == 0, "R1 reset forces master", isSlave, 0);
    chk(swTick == 0, "R1 tick low in reset", swTick, 0);
    chk(syncDrive == 0, "R1 drive low in reset", syncDrive, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t0 = cyc;
    waitTick(t);
    chk(t - t0 == DEF, "R1 first tick after reset", t - t0, DEF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule